// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block encrypts 128-bit blocks with AES-128 at a rate of one block per clock. All ten cipher rounds are laid out as separate hardware stages, and each stage registers its result. A block that enters on one cycle therefore moves one stage further on each of the following cycles, while newer blocks follow directly behind it. The fixed latency is eleven cycles: one stage for the initial key whitening and ten round stages.

The block does not expand the key. The caller works out the eleven round keys once for each key and holds them steady on a wide bank input for as long as that key is in use. The caller must not change the bank while blocks are still in flight. There is no backpressure: each block presented with `in_valid` appears at the output exactly eleven cycles later, flagged by `out_valid`. Gaps in the input stream reach the output as gaps of the same length.

Top module: `aes128_enc_pipe`

## Requirements
- R1: A new block is accepted on every rising edge where `in_valid` is high, including on consecutive edges, and each one produces its own output.
- R2: `out_valid` is high on exactly the cycle 11 edges after the edge that sampled the matching `in_valid`, and low otherwise.
- R3: Byte k of a block (k = 4*column + row, k = 0..15) sits in bits [127-8k:120-8k], so the first byte is in bits [127:120]. This holds for the plaintext, the ciphertext and each round key.
- R4: Round key r (r = 0..10) is read from `rk_bank[128*r+127:128*r]`, so round key 0 sits in the lowest 128 bits.
- R5: Before the first round, the state is XORed with round key 0.
- R6: Rounds 1 to 9 each apply byte substitution, then row rotation, then column mixing, then XOR with that round's key.
- R7: Round 10 applies substitution, rotation and key XOR, and skips column mixing.
- R8: Row rotation moves row r left by r byte positions: the new byte at (row r, column c) is the old byte at (row r, column (c+r) mod 4). Row 0 is unchanged.
- R9: Column mixing maps each column (a0,a1,a2,a3) to (2a0^3a1^a2^a3, a0^2a1^3a2^a3, a0^a1^2a2^3a3, 3a0^a1^a2^2a3). Multiplication is in GF(2^8), where doubling is a left shift followed by XOR with 0x1b when the bit shifted out was 1, and 3x = 2x ^ x.
- R10: Substitution replaces every byte in parallel with the affine image (XOR 0x63) of its inverse in GF(2^8). The inverse of 0 is taken as 0. No byte maps to itself or to its complement.
- R11: While reset is active, and until the first accepted block reaches the output, `out_valid` is low.
- R12: While `out_valid` is low after reset, `out_block` holds the most recent ciphertext.
- R13: Idle cycles between input blocks appear as idle cycles of the same length at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Qualifies `in_block` on this edge |
| in_block | input | 128 | Plaintext block, column-major byte order |
| rk_bank | input | 1408 | Eleven pre-expanded round keys, key 0 in the lowest slice |
| out_valid | output | 1 | Qualifies `out_block` |
| out_block | output | 128 | Ciphertext block, column-major byte order |

## Verification
Because the cipher diffuses well, a single wrong byte anywhere in a stage's state affects about half of the output bits two rounds later. The error therefore shows at `out_block` on the very cycle the affected block emerges, which is at most eleven cycles after it entered. A valid bit that is dropped or doubled in the stage chain shows at `out_valid` as a missing block, an extra block, or a block on the wrong cycle. An error inside one round function appears even earlier, in the stage-local invariants: the substitution has no fixed points, row 0 is untouched by the rotation, and each mixed column keeps the XOR of its four bytes.

// File: rtl/aes128_pipe_pkg.sv
package aes128_pipe_pkg;

  localparam int unsigned BLK_BITS = 128;
  localparam int unsigned BYTE_CNT = BLK_BITS / 8;

  typedef logic [BLK_BITS-1:0] blk_t;

  // GF(2^8) doubling with reduction by the AES polynomial
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_tri(input logic [7:0] a);
    return gf_dbl(a) ^ a;
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_dbl(x);
    end
    return acc;
  endfunction

  // a^254 equals the inverse for nonzero a, and gives 0 for a = 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] p, r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_byte(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] get_byte(input blk_t b, input int k);
    return b[BLK_BITS-1-8*k -: 8];
  endfunction

  function automatic blk_t sub_bytes(input blk_t s);
    blk_t o;
    for (int k = 0; k < BYTE_CNT; k++)
      o[BLK_BITS-1-8*k -: 8] = sbox_byte(get_byte(s, k));
    return o;
  endfunction

  function automatic blk_t shift_rows(input blk_t s);
    blk_t o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_BITS-1-8*(4*c+r) -: 8] = get_byte(s, 4*((c + r) % 4) + r);
    return o;
  endfunction

  function automatic logic [31:0] mix_one(input logic [31:0] col);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = col;
    return {gf_dbl(a0) ^ gf_tri(a1) ^ a2 ^ a3,
            a0 ^ gf_dbl(a1) ^ gf_tri(a2) ^ a3,
            a0 ^ a1 ^ gf_dbl(a2) ^ gf_tri(a3),
            gf_tri(a0) ^ a1 ^ a2 ^ gf_dbl(a3)};
  endfunction

  function automatic blk_t mix_columns(input blk_t s);
    blk_t o;
    for (int c = 0; c < 4; c++)
      o[BLK_BITS-1-32*c -: 32] = mix_one(s[BLK_BITS-1-32*c -: 32]);
    return o;
  endfunction

endpackage

// File: rtl/aes128_whiten_stage.sv
module aes128_whiten_stage
  import aes128_pipe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic v_i,
  input  blk_t d_i,
  input  blk_t rk_i,
  output logic v_o,
  output blk_t d_o
);

  blk_t mixed_w;
  assign mixed_w = d_i ^ rk_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) d_o <= mixed_w;
  end

endmodule

// File: rtl/aes128_round_stage.sv
module aes128_round_stage
  import aes128_pipe_pkg::*;
#(
  parameter bit LAST = 1'b0
)(
  input  logic clk,
  input  logic rst_n,
  input  logic v_i,
  input  blk_t d_i,
  input  blk_t rk_i,
  output logic v_o,
  output blk_t d_o
);

  blk_t sb_w, sr_w, mc_w, nxt_w;
  logic sbox_fix_hit;
  logic row0_kept;

  assign sb_w  = sub_bytes(d_i);
  assign sr_w  = shift_rows(sb_w);
  assign nxt_w = mc_w ^ rk_i;

  generate
    if (LAST) begin : g_final
      assign mc_w = sr_w;
    end else begin : g_mix
      logic col_par_ok;
      assign mc_w = mix_columns(sr_w);

      always_comb begin
        col_par_ok = 1'b1;
        for (int c = 0; c < 4; c++) begin
          if ((get_byte(mc_w, 4*c) ^ get_byte(mc_w, 4*c+1) ^
               get_byte(mc_w, 4*c+2) ^ get_byte(mc_w, 4*c+3)) !=
              (get_byte(sr_w, 4*c) ^ get_byte(sr_w, 4*c+1) ^
               get_byte(sr_w, 4*c+2) ^ get_byte(sr_w, 4*c+3)))
            col_par_ok = 1'b0;
        end
      end

      // R9
      mix_parity_chk: assert property (@(posedge clk) disable iff (!rst_n) col_par_ok);
    end
  endgenerate

  always_comb begin
    sbox_fix_hit = 1'b0;
    row0_kept    = 1'b1;
    for (int k = 0; k < BYTE_CNT; k++) begin
      if (get_byte(sb_w, k) == get_byte(d_i, k) ||
          get_byte(sb_w, k) == ~get_byte(d_i, k))
        sbox_fix_hit = 1'b1;
    end
    for (int c = 0; c < 4; c++) begin
      if (get_byte(sr_w, 4*c) != get_byte(sb_w, 4*c)) row0_kept = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) d_o <= nxt_w;
  end

  // R10
  sbox_nofix_chk: assert property (@(posedge clk) disable iff (!rst_n) !sbox_fix_hit);

  // R8
  row0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) row0_kept);

endmodule

// File: rtl/aes128_enc_pipe.sv
module aes128_enc_pipe
  import aes128_pipe_pkg::*;
#(
  parameter int unsigned NR = 10
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [BLK_BITS-1:0]           in_block,
  input  logic [BLK_BITS*(NR+1)-1:0]    rk_bank,
  output logic                          out_valid,
  output logic [BLK_BITS-1:0]           out_block
);

  localparam int unsigned LAT   = NR + 1;
  localparam int unsigned CNT_W = $clog2(LAT + 1);

  logic st_v [NR+1];
  blk_t st_d [NR+1];

  aes128_whiten_stage u_whiten (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (in_valid),
    .d_i   (in_block),
    .rk_i  (rk_bank[BLK_BITS-1:0]),
    .v_o   (st_v[0]),
    .d_o   (st_d[0])
  );

  generate
    for (genvar i = 1; i <= NR; i++) begin : g_rnd
      aes128_round_stage #(.LAST(i == NR)) u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (st_v[i-1]),
        .d_i   (st_d[i-1]),
        .rk_i  (rk_bank[BLK_BITS*i +: BLK_BITS]),
        .v_o   (st_v[i]),
        .d_o   (st_d[i])
      );
    end
  endgenerate

  assign out_valid = st_v[NR];
  assign out_block = st_d[NR];

  // cycles since reset release, saturating; used only to bound look-back
  logic [CNT_W-1:0] rst_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rst_cnt <= '0;
    else if (rst_cnt != CNT_W'(LAT)) rst_cnt <= rst_cnt + 1'b1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cnt == CNT_W'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

  // R11
  early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cnt < CNT_W'(LAT)) |-> !out_valid);

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_cnt != '0) && !out_valid) |-> $stable(out_block));

endmodule

// File: tb/aes128_enc_pipe_bench.sv
module aes128_enc_pipe_bench;

  localparam int NRND = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [127:0] in_block = '0;
  logic [128*(NRND+1)-1:0] rk_bank = '0;
  logic out_valid;
  logic [127:0] out_block;

  aes128_enc_pipe u_aes128_enc_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
    .rk_bank(rk_bank), .out_valid(out_valid), .out_block(out_block)
  );

  always #5 clk = ~clk;

  typedef struct {
    int           due;
    logic [127:0] data;
    int           kat;
    string        tag;
  } exp_t;

  exp_t         expq[$];
  int           total = 0;
  int           bad = 0;
  int           cyc = 0;
  logic         rst_q = 1'b0;
  logic         seen_out = 1'b0;
  logic [127:0] last_out = '0;
  logic [7:0]   sb [256];

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    rst_q <= rst_n;
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // substitution table built from powers of the generator 3 and its inverse chain
  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    for (int n = 0; n < 255; n++) begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end
    sb[0] = 8'h63;
  endtask

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, aa, bb;
    acc = 0; aa = a; bb = b;
    while (bb != 0) begin
      if (bb[0]) acc = acc ^ aa;
      aa = (aa[7]) ? ((aa << 1) ^ 8'h1b) : (aa << 1);
      bb = bb >> 1;
    end
    return acc;
  endfunction

  task automatic load_key(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = gm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= NRND; r++)
      rk_bank[128*r +: 128] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] a0, a1, a2, a3;
    logic [127:0] res;
    for (int k = 0; k < 16; k++) s[k] = pt[127-8*k -: 8] ^ rk_bank[127-8*k -: 8];
    for (int rnd = 1; rnd <= NRND; rnd++) begin
      for (int k = 0; k < 16; k++) t[k] = sb[s[k]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
      if (rnd < NRND) begin
        for (int c = 0; c < 4; c++) begin
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = gm(a0,2) ^ gm(a1,3) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ gm(a1,2) ^ gm(a2,3) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ gm(a2,2) ^ gm(a3,3);
          s[4*c+3] = gm(a0,3) ^ a1 ^ a2 ^ gm(a3,2);
        end
      end
      for (int k = 0; k < 16; k++) s[k] = s[k] ^ rk_bank[128*rnd + 127 - 8*k -: 8];
    end
    for (int k = 0; k < 16; k++) res[127-8*k -: 8] = s[k];
    return res;
  endfunction

  // output checks, once per cycle away from the active edge
  always @(negedge clk) begin
    if (!rst_q) begin
      chk(out_valid == 1'b0, "R11 valid low in reset", {127'b0, out_valid}, 128'd0);
    end else if (expq.size() > 0 && expq[0].due == cyc) begin
      chk(out_valid == 1'b1, {"R2 latency ", expq[0].tag}, {127'b0, out_valid}, 128'd1);
      chk(out_block == expq[0].data, {expq[0].tag, " R5 R6 R7 R8 R9 R10 model"}, out_block, expq[0].data);
      if (expq[0].kat == 1)
        chk(out_block == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 R4 known answer A", out_block,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a);
      if (expq[0].kat == 2)
        chk(out_block == 128'h3925841d02dc09fbdc118597196a0b32, "R3 R4 known answer B", out_block,
            128'h3925841d02dc09fbdc118597196a0b32);
      seen_out = 1'b1;
      last_out = expq[0].data;
      void'(expq.pop_front());
    end else begin
      chk(out_valid == 1'b0, "R2 R11 R13 no output expected", {127'b0, out_valid}, 128'd0);
      if (seen_out) chk(out_block == last_out, "R12 hold while idle", out_block, last_out);
    end
  end

  task automatic send(input logic [127:0] d, input int kat, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_block = d;
    expq.push_back('{due: cyc + 11, data: ref_enc(d), kat: kat, tag: tag});
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_block = ~in_block;
    end
  endtask

  initial begin
    build_sbox();
    load_key(128'h000102030405060708090a0b0c0d0e0f);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // known answer, key A
    send(128'h00112233445566778899aabbccddeeff, 1, "R3");
    idle(14);
    // back-to-back stream
    for (int i = 0; i < 20; i++)
      send({4{32'h9e3779b9 * (i + 1)}} ^ {i[7:0], 120'h5a}, 0, "R1 back-to-back");
    idle(14);
    // gaps of varying length
    for (int i = 0; i < 6; i++) begin
      send({32'hc0ffee00 + i, 96'h0123456789abcdef01234567} ^ {16{i[7:0]}}, 0, "R13 gapped");
      idle(i % 3 + 1);
    end
    idle(14);
    // new round-key bank, then known answer B and a short burst
    load_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
    idle(2);
    send(128'h3243f6a8885a308d313198a2e0370734, 2, "R4");
    for (int i = 0; i < 8; i++)
      send({8{i[7:0], 8'ha5}}, 0, "R1 R4 burst key B");
    idle(16);
    chk(expq.size() == 0, "R1 all blocks emerged", 128'(expq.size()), 128'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog expired act=%0d exp=%0d", cyc, 5000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule